// File: doc/BRIEF.md
# PLL Output Phase Stepper

This block moves one chosen output of a multi-output PLL to a requested phase offset while the PLL keeps running. The PLL offers only a stepping interface: a field that names the output to act on, a one-cycle step pulse, and a direction bit. Each pulse shifts the named output by one fixed step, and 64 steps make one full turn of 360 degrees. The controller keeps its own record of where the adjustable output sits. It picks the shorter way around the circle to reach a new target, and sends the pulses one at a time. After each pulse it waits for the PLL's completion acknowledge before it sends the next one.

Output 0 of the PLL is the 0-degree system clock and output 1 is a fixed 90-degree clock. This controller never touches either of them. Only output 2 is stepped. After reset that output is at step 0. A calibration engine sits above the block and hands it target positions through a valid/ready request port. The request carries no buffering. `req_ready` is high only while the controller is idle, and a request is taken on the rising clock edge where `req_valid` and `req_ready` are both high. While a move is in progress, `req_ready` stays low, so the requester must hold or drop its request. Nothing offered during that time is stored.

Top module: `phase_step_ctrl`

## Requirements
- R1: After reset, `cur_phase` is 0, `busy` is 0, `req_ready` is 1, `pll_step` is 0 and `pll_sel` drives the idle index 0.
- R2: For a taken target T and current position C, let d = (T - C) mod 64. If d is in 1..32, the controller sends exactly d pulses with `pll_dir` = 1 (later phase, position increments). If d is in 33..63, it sends exactly 64 - d pulses with `pll_dir` = 0 (earlier phase, position decrements).
- R3: A taken request whose target equals the current position sends no pulse, and `busy` stays low.
- R4: `pll_step` is high for exactly one cycle per step. No further pulse is sent until `pll_done` has been seen high for the previous pulse.
- R5: `cur_phase` changes by one, modulo 64, on each acknowledged step, in the direction of `pll_dir`. It wraps from 63 to 0 and from 0 to 63. At the end of a move it equals the target.
- R6: While `busy` is high, `pll_sel` is 2 and does not change. It is already 2 in the cycle before the first pulse and is still 2 in the cycle after the final acknowledge. While idle, `pll_sel` is 0.
- R7: `busy` rises in the cycle after a request with nonzero distance is taken, and falls one cycle after the final acknowledge. `req_ready` is the inverse of `busy`. A `req_valid` offered while busy has no effect on the pulses or on the final position.
- R8: A `pll_done` that arrives while no step is outstanding is ignored: `cur_phase` and `busy` do not change.
- R9: `pll_dir` does not change during a move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A target position is offered |
| req_ready | output | 1 | Controller is idle and takes a request this cycle |
| req_target | input | 6 | Requested phase position in steps, 0..63 |
| pll_sel | output | 2 | PLL output index to step |
| pll_step | output | 1 | One-cycle step pulse to the PLL |
| pll_dir | output | 1 | Step direction: 1 later, 0 earlier |
| pll_done | input | 1 | PLL acknowledge that a step has completed |
| busy | output | 1 | A move is in progress |
| cur_phase | output | 6 | Current tracked position of the adjustable output |

## Verification
The main sweep moves from eight start positions to every one of the 64 targets, with the PLL acknowledge latency rotating between 1 and 3 cycles. The start positions include 0, 31, 32, 33 and 63, so the sweep covers both wrap directions, the d = 32 tie (which must go up) and d = 33 (the first distance that goes down). The pulse count and direction seen by a model PLL phase counter separate a wrong choice of direction from a wrong count. Comparing the model's final phase with `cur_phase` catches bookkeeping drift. Three directed patterns cover the rest: a same-target request, which must leave `busy` low; a request held on the port during a long move, which must change nothing; and a stray acknowledge while idle, which must leave the position alone.

// File: rtl/pstep_pkg.sv
package pstep_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARM   = 3'd1,
    ST_PULSE = 3'd2,
    ST_WAIT  = 3'd3,
    ST_HOLD  = 3'd4
  } step_state_t;

  typedef struct packed {
    logic later;
    logic none;
  } plan_flags_t;

endpackage

// File: rtl/pstep_planner.sv
module pstep_planner #(
  parameter int PHASE_W = 6
) (
  input  logic [PHASE_W-1:0]   cur,
  input  logic [PHASE_W-1:0]   tgt,
  output pstep_pkg::plan_flags_t flags,
  output logic [PHASE_W-1:0]   count
);
  localparam int HALF_I = 1 << (PHASE_W - 1);
  localparam logic [PHASE_W-1:0] HALF = PHASE_W'(HALF_I);

  logic [PHASE_W-1:0] fwd;
  logic [PHASE_W-1:0] back;

  always_comb begin
    fwd         = tgt - cur;
    back        = cur - tgt;
    flags.none  = (fwd == '0);
    flags.later = (fwd <= HALF);
    count       = flags.later ? fwd : back;
  end

endmodule

// File: rtl/pstep_position.sv
module pstep_position #(
  parameter int PHASE_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv,
  input  logic               later,
  output logic [PHASE_W-1:0] pos
);
  localparam logic [PHASE_W-1:0] ONE = PHASE_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pos <= '0;
    else if (adv)
      pos <= later ? pos + ONE : pos - ONE;
  end

  AST_POS_UNIT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pos) |-> (pos == $past(pos) + ONE) || (pos == $past(pos) - ONE)); // R5

endmodule

// File: rtl/pstep_seq.sv
module pstep_seq #(
  parameter int PHASE_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               plan_later,
  input  logic [PHASE_W-1:0] plan_count,
  input  logic               done,
  output logic               active,
  output logic               step,
  output logic               later,
  output logic               adv
);
  import pstep_pkg::*;

  localparam logic [PHASE_W-1:0] ONE = PHASE_W'(1);

  step_state_t        state;
  logic [PHASE_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      remain <= '0;
      later  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state  <= ST_ARM;
          remain <= plan_count;
          later  <= plan_later;
        end
        ST_ARM:   state <= ST_PULSE;
        ST_PULSE: state <= ST_WAIT;
        ST_WAIT: if (done) begin
          remain <= remain - ONE;
          state  <= (remain == ONE) ? ST_HOLD : ST_PULSE;
        end
        ST_HOLD:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    active = (state != ST_IDLE);
    step   = (state == ST_PULSE);
    adv    = (state == ST_WAIT) && done;
  end

  AST_STEP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> !step); // R4
  AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    active && $past(active) |-> $stable(later)); // R9
  AST_REMAIN_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PULSE || state == ST_WAIT) |-> remain != '0); // R2
  AST_NO_ADV_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !adv); // R8

endmodule

// File: rtl/phase_step_ctrl.sv
module phase_step_ctrl #(
  parameter int PHASE_W  = 6,
  parameter int SEL_W    = 2,
  parameter int ADJ_IDX  = 2,
  parameter int IDLE_IDX = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [PHASE_W-1:0] req_target,
  output logic [SEL_W-1:0]   pll_sel,
  output logic               pll_step,
  output logic               pll_dir,
  input  logic               pll_done,
  output logic               busy,
  output logic [PHASE_W-1:0] cur_phase
);
  localparam logic [SEL_W-1:0] SEL_ADJ  = SEL_W'(ADJ_IDX);
  localparam logic [SEL_W-1:0] SEL_IDLE = SEL_W'(IDLE_IDX);

  pstep_pkg::plan_flags_t flags;
  logic [PHASE_W-1:0]     plan_count;
  logic                   take;
  logic                   start;
  logic                   adv;

  pstep_planner #(.PHASE_W(PHASE_W)) u_plan (
    .cur   (cur_phase),
    .tgt   (req_target),
    .flags (flags),
    .count (plan_count)
  );

  pstep_seq #(.PHASE_W(PHASE_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .plan_later (flags.later),
    .plan_count (plan_count),
    .done       (pll_done),
    .active     (busy),
    .step       (pll_step),
    .later      (pll_dir),
    .adv        (adv)
  );

  pstep_position #(.PHASE_W(PHASE_W)) u_pos (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (adv),
    .later (pll_dir),
    .pos   (cur_phase)
  );

  always_comb begin
    req_ready = !busy;
    take      = req_valid && req_ready;
    start     = take && !flags.none;
    pll_sel   = busy ? SEL_ADJ : SEL_IDLE;
  end

  AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(pll_sel)); // R6
  AST_STEP_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    pll_step |-> busy && pll_sel == SEL_ADJ); // R6
  AST_NO_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready); // R7
  AST_IDLE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !$past(busy) |-> $stable(cur_phase)); // R8

endmodule

// File: tb/phase_step_ctrl_bench.sv
`timescale 1ns/1ps
module phase_step_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [5:0] req_target = '0;
  logic [1:0] pll_sel;
  logic       pll_step;
  logic       pll_dir;
  logic       pll_done = 1'b0;
  logic       busy;
  logic [5:0] cur_phase;

  always #10 clk = ~clk;

  phase_step_ctrl u_phase_step_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_target(req_target), .pll_sel(pll_sel), .pll_step(pll_step),
    .pll_dir(pll_dir), .pll_done(pll_done), .busy(busy), .cur_phase(cur_phase)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // PLL model: phase counter with programmable acknowledge latency
  int  lat = 1;
  int  lat_cnt = 0;
  bit  pend = 0;
  bit  pend_dir = 0;
  bit  hold_chk = 0;
  bit  inject = 0;
  int  steps = 0;
  int  dir_bad = 0;
  bit  exp_dir = 0;
  bit  busy_seen = 0;
  int  model_phase = 0;

  always @(negedge clk) begin
    if (hold_chk) begin
      chk(busy && pll_sel == 2'd2, "R6", pll_sel, 2);
      hold_chk = 0;
    end
    pll_done = 1'b0;
    if (inject) begin
      pll_done = 1'b1;
      inject = 0;
    end
    if (pend) begin
      if (lat_cnt == 0) begin
        pll_done = 1'b1;
        pend = 0;
        model_phase = pend_dir ? (model_phase + 1) % 64 : (model_phase + 63) % 64;
        hold_chk = 1;
      end else lat_cnt--;
    end
    if (busy) busy_seen = 1;
    if (pll_step) begin
      chk(!pend, "R4", pend, 0);
      chk(pll_sel == 2'd2, "R6", pll_sel, 2);
      pend = 1;
      pend_dir = pll_dir;
      lat_cnt = lat - 1;
      steps++;
      if (pll_dir != exp_dir) dir_bad++;
    end
  end

  int exp_pos = 0;

  task automatic do_op(input int t, input int l);
    int d, n, cyc;
    lat = l;
    d = (t - exp_pos + 64) % 64;
    if (d == 0) n = 0;
    else if (d <= 32) begin n = d; exp_dir = 1; end
    else begin n = 64 - d; exp_dir = 0; end
    steps = 0; dir_bad = 0;
    cyc = 0;
    while (!req_ready && cyc < 500) begin @(negedge clk); cyc++; end
    req_valid = 1'b1;
    req_target = 6'(t);
    @(negedge clk);
    req_valid = 1'b0;
    busy_seen = busy;
    cyc = 0;
    while (busy && cyc < 1000) begin @(negedge clk); cyc++; end
    @(negedge clk);
    chk(steps == n, "R2", steps, n);
    chk(dir_bad == 0, "R2", dir_bad, 0);
    chk(cur_phase == 6'(t), "R5", cur_phase, t);
    chk(model_phase == t, "R5", model_phase, t);
    chk(pll_sel == 2'd0 && req_ready, "R6", pll_sel, 0);
    if (n == 0) chk(!busy_seen, "R3", busy_seen, 0);
    exp_pos = t;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      chk(0, "WATCHDOG", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int starts[8] = '{0, 7, 13, 31, 32, 33, 50, 63};
    int k = 0;
    int first;
    int tmp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cur_phase == 0, "R1", cur_phase, 0);
    chk(!busy && req_ready, "R1", busy, 0);
    chk(!pll_step && pll_sel == 2'd0, "R1", pll_sel, 0);

    // R2/R5 sweep: every target from several start positions
    foreach (starts[s]) begin
      for (int t = 0; t < 64; t++) begin
        do_op(starts[s], 1 + (k % 3));
        do_op(t, 1 + ((k + 1) % 3));
        k++;
      end
    end

    // R3 same target twice
    do_op(20, 2);
    do_op(20, 2);

    // R7 requests while busy are ignored
    lat = 3;
    first = (exp_pos + 10) % 64;
    req_valid = 1'b1;
    req_target = 6'(first);
    @(negedge clk);
    chk(busy, "R7", busy, 1);
    for (int i = 0; i < 4; i++) begin
      req_target = 6'((exp_pos + 40) % 64);
      chk(!req_ready, "R7", req_ready, 0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    tmp = 0;
    while (busy && tmp < 1000) begin @(negedge clk); tmp++; end
    @(negedge clk);
    chk(cur_phase == 6'(first), "R7", cur_phase, first);
    exp_pos = first;

    // R8 stray acknowledge while idle
    inject = 1;
    repeat (3) @(negedge clk);
    chk(cur_phase == 6'(exp_pos), "R8", cur_phase, exp_pos);
    chk(!busy, "R8", busy, 0);
    do_op((exp_pos + 1) % 64, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule